// File: doc/BRIEF.md
# Indirect Register Access Mailbox

This block lets host software reach a large internal register space through four small host registers. Software loads a word address and, for a write, a data word. It then writes a command code into the command/status register. The mailbox runs exactly one transfer on an internal 32-bit request/response port. For a read, it captures the returned word into a read-data register. Busy, done, error and overrun flags report how the transfer is going. Loading the address or data registers never starts a transfer on its own.

The host side is a plain single-cycle register port. A write takes effect on the clock edge where `host_we` is high. `host_rdata` is a combinational view of the register chosen by `host_sel`. The register selects are: 0 for command/status, 1 for address, 2 for write data and 3 for read data. The internal side raises a request and holds it until the target accepts it with `int_ready`. The mailbox then waits for `int_rvalid`, which both reads and writes return.

Top module: `csr_mailbox`

## Requirements
- R1: The address register keeps bits [25:2] of a host write to select 1. It reads back with bits [1:0] and [31:26] as zero. `int_addr` equals that field shifted left by two.
- R2: The write-data register (select 2) is separate from the address register. It reads back as written and is driven on `int_wdata` during a write transfer.
- R3: Writes to select 1 or select 2 never raise `int_req`. Only a write to select 0 can start a transfer.
- R4: Command code 0x1 (in bits [3:0] of a write to select 0) issues one request with `int_we` high. `int_req`, `int_addr`, `int_wdata` and `int_we` stay stable until the cycle `int_ready` is seen.
- R5: Command code 0x2 issues one request with `int_we` low. The read-data register loads `int_rdata` on the edge where `int_rvalid` is seen, and select 3 returns it.
- R6: Command code 0x0 starts no transfer and never sets busy. It sets done on the edge that accepts it.
- R7: Any code other than 0x0, 0x1 or 0x2 sets error (status bit 10) and done, and starts no transfer. The next accepted command clears error.
- R8: Busy (status bit 8) is high from the edge that accepts a read or write until the edge that sees `int_rvalid`. Done (status bit 9) is sticky and is cleared when the next read or write is accepted.
- R9: A command written while busy is dropped and sets overrun (status bit 11). Overrun stays set until the next accepted command.
- R10: While busy, writes to the address and write-data registers are ignored.
- R11: Status bits [3:0] show the code of the last accepted command. After reset, every host register reads zero and `int_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected host register contents |
| int_req | output | 1 | Internal transfer request |
| int_we | output | 1 | Internal transfer is a write |
| int_addr | output | 26 | Internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_ready | input | 1 | Target accepts the request |
| int_rvalid | input | 1 | Target response valid |
| int_rdata | input | 32 | Target response data |

## Verification
The two functions that can fall on the same clock edge are completion, when `int_rvalid` arrives, and a new host command. Both must be judged on that one edge: busy drops while the command is still treated as arriving during the transfer. The bench waits until it sees `int_rvalid` high and drives a command write in that same cycle. It then expects done and overrun both set, busy clear, and no further request on the internal port. A second check does the same for address and data loads made during a long ready stall. The registers must read back unchanged, and the stalled request must keep its address, data and direction.

// File: rtl/csr_mailbox_pkg.sv
package csr_mailbox_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_NOP = 4'h0;
  localparam logic [CMD_W-1:0] CMD_WR  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_RD  = 4'h2;

  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_WDATA = 2'd2;
  localparam logic [1:0] SEL_RDATA = 2'd3;

  localparam int ST_BUSY = 8;
  localparam int ST_DONE = 9;
  localparam int ST_ERR  = 10;
  localparam int ST_OVR  = 11;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_t;

  typedef struct packed {
    logic nop;
    logic wr;
    logic rd;
    logic bad;
  } cmd_dec_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import csr_mailbox_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output cmd_dec_t         dec
);
  always_comb begin
    dec.nop = (code == CMD_NOP);
    dec.wr  = (code == CMD_WR);
    dec.rd  = (code == CMD_RD);
    dec.bad = !(dec.nop || dec.wr || dec.rd);
  end
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import csr_mailbox_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] rd_resp,
  input  logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-3:0] addr_field,
  output logic [DATA_W-1:0] wdata
);
  localparam int FIELD_W = ADDR_W - 2;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [FIELD_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  wdat_q, wdat_d;
  logic [DATA_W-1:0]  rdat_q, rdat_d;
  logic               load_en;

  assign load_en = host_we && !busy;

  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (load_en && host_sel == SEL_ADDR)  addr_d = host_wdata[ADDR_W-1:2];
    if (load_en && host_sel == SEL_WDATA) wdat_d = host_wdata;
    if (rd_capture)                       rdat_d = rd_resp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  always_comb begin
    unique case (host_sel)
      SEL_CMD:   host_rdata = status_word;
      SEL_ADDR:  host_rdata = {{PAD_W{1'b0}}, addr_q, 2'b00};
      SEL_WDATA: host_rdata = wdat_q;
      default:   host_rdata = rdat_q;
    endcase
  end

  assign addr_field = addr_q;
  assign wdata      = wdat_q;
endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
  import csr_mailbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  cmd_dec_t         dec,
  input  logic             int_ready,
  input  logic             int_rvalid,
  output logic             int_req,
  output logic             int_we,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             ovr,
  output logic [CMD_W-1:0] last_code,
  output logic             rd_capture
);
  seq_state_t       st_q, st_d;
  logic             we_q, we_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             ovr_q, ovr_d;
  logic [CMD_W-1:0] code_q, code_d;
  logic             accept, finish;

  assign accept = cmd_wr && (st_q == SQ_IDLE);
  assign finish = (st_q == SQ_WAIT) && int_rvalid;

  always_comb begin
    st_d   = st_q;
    we_d   = we_q;
    done_d = done_q;
    err_d  = err_q;
    ovr_d  = ovr_q;
    code_d = code_q;
    unique case (st_q)
      SQ_IDLE: if (accept && (dec.wr || dec.rd)) begin
        st_d = SQ_REQ;
        we_d = dec.wr;
      end
      SQ_REQ:  if (int_ready) st_d = SQ_WAIT;
      default: if (int_rvalid) st_d = SQ_IDLE;
    endcase
    if (accept) begin
      code_d = cmd_code;
      done_d = dec.nop || dec.bad;
      err_d  = dec.bad;
      ovr_d  = 1'b0;
    end
    if (cmd_wr && !accept) ovr_d = 1'b1;
    if (finish) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      we_q   <= we_d;
      done_q <= done_d;
      err_q  <= err_d;
      ovr_q  <= ovr_d;
      code_q <= code_d;
    end
  end

  assign int_req    = (st_q == SQ_REQ);
  assign int_we     = we_q;
  assign busy       = (st_q != SQ_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign ovr        = ovr_q;
  assign last_code  = code_q;
  assign rd_capture = finish && !we_q;
endmodule

// File: rtl/csr_mailbox.sv
module csr_mailbox
  import csr_mailbox_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              int_req,
  output logic              int_we,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic              int_ready,
  input  logic              int_rvalid,
  input  logic [DATA_W-1:0] int_rdata
);
  localparam int FIELD_W = ADDR_W - 2;

  logic [1:0]         rst_sync;
  logic               rst_q_n;
  logic               cmd_wr;
  logic [CMD_W-1:0]   cmd_code;
  cmd_dec_t           dec;
  logic               busy, done, err, ovr, rd_capture;
  logic [CMD_W-1:0]   last_code;
  logic [DATA_W-1:0]  status_word;
  logic [FIELD_W-1:0] addr_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign cmd_wr   = host_we && (host_sel == SEL_CMD);
  assign cmd_code = host_wdata[CMD_W-1:0];

  mbx_cmd_decode u_dec (.code(cmd_code), .dec(dec));

  mbx_sequencer u_seq (
    .clk(clk), .rst_n(rst_q_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .dec(dec),
    .int_ready(int_ready), .int_rvalid(int_rvalid), .int_req(int_req), .int_we(int_we),
    .busy(busy), .done(done), .err(err), .ovr(ovr), .last_code(last_code),
    .rd_capture(rd_capture)
  );

  always_comb begin
    status_word           = '0;
    status_word[CMD_W-1:0] = last_code;
    status_word[ST_BUSY]  = busy;
    status_word[ST_DONE]  = done;
    status_word[ST_ERR]   = err;
    status_word[ST_OVR]   = ovr;
  end

  mbx_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .busy(busy), .rd_capture(rd_capture), .rd_resp(int_rdata),
    .status_word(status_word), .host_rdata(host_rdata), .addr_field(addr_field),
    .wdata(int_wdata)
  );

  assign int_addr = {addr_field, 2'b00};
endmodule

// File: rtl/csr_mailbox_chk.sv
module csr_mailbox_chk
  import csr_mailbox_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic [CMD_W-1:0]  cmd_code,
  input logic              busy,
  input logic              done,
  input logic              ovr,
  input logic              rd_capture,
  input logic              int_req,
  input logic              int_we,
  input logic [ADDR_W-1:0] int_addr,
  input logic [DATA_W-1:0] int_wdata,
  input logic              int_ready,
  input logic [DATA_W-1:0] int_rdata,
  input logic [1:0]        host_sel,
  input logic [DATA_W-1:0] host_rdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ready |=> int_req && $stable(int_addr) && $stable(int_wdata) && $stable(int_we)); // R4

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_wr |=> !int_req); // R3

  AST_NOACCESS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && cmd_code != CMD_WR && cmd_code != CMD_RD |=> !int_req && !busy && done); // R6

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy |=> ovr); // R9

  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture && host_sel == SEL_RDATA |=> host_sel != SEL_RDATA || host_rdata == $past(int_rdata)); // R5
endmodule

bind csr_mailbox csr_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .busy(busy),
  .done(done), .ovr(ovr), .rd_capture(rd_capture), .int_req(int_req), .int_we(int_we),
  .int_addr(int_addr), .int_wdata(int_wdata), .int_ready(int_ready), .int_rdata(int_rdata),
  .host_sel(host_sel), .host_rdata(host_rdata)
);

// File: tb/sim_csr_mailbox.sv
module sim_csr_mailbox;
  logic        clk, rst_n;
  logic        host_we;
  logic [1:0]  host_sel;
  logic [31:0] host_wdata, host_rdata;
  logic        int_req, int_we, int_ready, int_rvalid;
  logic [25:0] int_addr;
  logic [31:0] int_wdata, int_rdata;

  int checks = 0, failures = 0;
  int req_cnt = 0, hold_bad = 0;
  int ready_dly = 0, resp_dly = 0;
  logic [31:0] resp_val = 32'h0;
  logic [25:0] seen_addr;
  logic        seen_we;
  logic [31:0] seen_wdata;

  csr_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .int_req(int_req), .int_we(int_we),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_ready(int_ready),
    .int_rvalid(int_rvalid), .int_rdata(int_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // target model
  initial begin
    int_ready = 1'b0; int_rvalid = 1'b0; int_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (int_req === 1'b1) begin
        req_cnt++;
        seen_addr = int_addr; seen_we = int_we; seen_wdata = int_wdata;
        for (int i = 0; i < ready_dly; i++) begin
          @(negedge clk);
          if (int_req !== 1'b1 || int_addr !== seen_addr || int_we !== seen_we ||
              int_wdata !== seen_wdata) hold_bad++;
        end
        int_ready = 1'b1;
        @(negedge clk);
        int_ready = 1'b0;
        for (int i = 0; i < resp_dly; i++) @(negedge clk);
        int_rvalid = 1'b1; int_rdata = resp_val;
        @(negedge clk);
        int_rvalid = 1'b0; int_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  task automatic hwrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [31:0] val);
    host_sel = sel;
    #1;
    val = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      hread(2'd0, s);
      if (!s[8]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      hread(s[1:0], v);
      chk("R11 reset register value", v, 32'h0);
    end
    chk("R11 reset int_req", {31'h0, int_req}, 32'h0);
  endtask

  task automatic t_load_only();
    logic [31:0] v;
    int base = req_cnt;
    hwrite(2'd1, 32'h0160_4010);
    hwrite(2'd2, 32'h1234_5678);
    repeat (5) @(negedge clk);
    chk("R3 no request from loads", req_cnt - base, 0);
    hread(2'd1, v); chk("R1 address readback", v, 32'h0160_4010);
    hwrite(2'd1, 32'hFFFF_FFFF);
    hread(2'd1, v); chk("R1 address field masking", v, 32'h03FF_FFFC);
    hread(2'd2, v); chk("R2 write-data readback", v, 32'h1234_5678);
    hwrite(2'd1, 32'h0160_4010);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int base = req_cnt;
    ready_dly = 3; resp_dly = 2; hold_bad = 0;
    hwrite(2'd0, 32'h1);
    #1; hread(2'd0, v);
    chk("R8 busy after accept", {31'h0, v[8]}, 32'h1);
    chk("R8 done cleared on accept", {31'h0, v[9]}, 32'h0);
    wait_idle();
    chk("R4 one write request", req_cnt - base, 1);
    chk("R4 write enable", {31'h0, seen_we}, 32'h1);
    chk("R1 internal byte address", {6'h0, seen_addr}, 32'h0160_4010);
    chk("R2 internal write data", seen_wdata, 32'h1234_5678);
    chk("R4 request held stable", hold_bad, 0);
    hread(2'd0, v);
    chk("R11 status after write", v, 32'h0000_0201);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int base = req_cnt;
    ready_dly = 0; resp_dly = 0; resp_val = 32'hA5A5_1234;
    hwrite(2'd0, 32'h2);
    wait_idle();
    chk("R5 one read request", req_cnt - base, 1);
    chk("R5 read direction", {31'h0, seen_we}, 32'h0);
    hread(2'd3, v); chk("R5 read data captured", v, 32'hA5A5_1234);
    hread(2'd0, v); chk("R8 done after read", v, 32'h0000_0202);
  endtask

  task automatic t_nop();
    logic [31:0] v;
    int base = req_cnt;
    hwrite(2'd0, 32'h0);
    #1; hread(2'd0, v);
    chk("R6 nop status", v, 32'h0000_0200);
    repeat (4) @(negedge clk);
    chk("R6 nop no request", req_cnt - base, 0);
  endtask

  task automatic t_bad();
    logic [31:0] v;
    int base = req_cnt;
    hwrite(2'd0, 32'h5);
    #1; hread(2'd0, v);
    chk("R7 error and done", v, 32'h0000_0605);
    repeat (4) @(negedge clk);
    chk("R7 bad code no request", req_cnt - base, 0);
    hwrite(2'd0, 32'h0);
    #1; hread(2'd0, v);
    chk("R7 error cleared by next command", {31'h0, v[10]}, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    int base = req_cnt;
    ready_dly = 8; resp_dly = 1; resp_val = 32'h0BAD_F00D; hold_bad = 0;
    hwrite(2'd0, 32'h2);
    hwrite(2'd0, 32'h1);
    hwrite(2'd1, 32'h0000_0100);
    hwrite(2'd2, 32'hCAFE_CAFE);
    #1; hread(2'd0, v);
    chk("R9 overrun while busy", v, 32'h0000_0902);
    hread(2'd1, v); chk("R10 address kept while busy", v, 32'h0160_4010);
    hread(2'd2, v); chk("R10 write data kept while busy", v, 32'h1234_5678);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 dropped command gave no request", req_cnt - base, 1);
    chk("R4 held through long stall", hold_bad, 0);
    hread(2'd3, v); chk("R5 read data after stall", v, 32'h0BAD_F00D);
    hwrite(2'd0, 32'h0);
    #1; hread(2'd0, v);
    chk("R9 overrun cleared", {31'h0, v[11]}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int base = req_cnt;
    ready_dly = 1; resp_dly = 2;
    hwrite(2'd0, 32'h1);
    do begin @(negedge clk); #1; end while (int_rvalid !== 1'b1);
    host_we = 1'b1; host_sel = 2'd0; host_wdata = 32'h2;
    @(negedge clk);
    host_we = 1'b0;
    #1; hread(2'd0, v);
    chk("R9 command on completion edge overruns", v, 32'h0000_0A01);
    repeat (5) @(negedge clk);
    chk("R8 no access after collision", req_cnt - base, 1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_sel = 2'd0; host_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_only();
    t_write();
    t_read();
    t_nop();
    t_bad();
    t_overrun();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule